// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block produces the value a host sees when it reads a flash device while an internal program or erase algorithm is running, and drives the ready/busy indication for the same period. A start strobe, qualified by an operation type, launches an operation. The block captures the data byte being programmed, or the sector being erased. An internal cycle counter stands in for the program and erase durations. When the count expires, the operation ends and reads return array data again.

While an operation is running, each read returns a status word in place of array data. The top bit is a polling bit. During a program it is the complement of the top bit of the data being written. During an erase it is zero. The next bit down is a toggle bit, which flips on every status read. An erase can be suspended. After a fixed latency the timer stops and ready is raised. Reads of other sectors then return array data, while reads of the sector being erased still return toggling status. A resume continues the count from where it stopped. The active-low asynchronous reset aborts any operation.

Top module: `eo_status_rpt`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, ready_o is 1 and rd_data_o is 0.
- R2: With no operation pending, a read (rd_i high at a clock edge) returns array_data_i on rd_data_o after that edge. rd_data_o changes only at edges where rd_i is high.
- R3: start_i accepted when idle drops ready_o in the next cycle. ready_o stays low for exactly PROG_CYCLES cycles for a program (op_erase_i=0) or ERASE_CYCLES cycles for an erase (op_erase_i=1), counting from the edge where start_i is sampled.
- R4: A read during a program returns bit DATA_W-1 equal to the inverse of bit DATA_W-1 of the captured prog_data_i.
- R5: A read during an erase, including the suspend latency, returns bit DATA_W-1 equal to 0.
- R6: In a status word, bit DATA_W-2 is 0 on the first status read after start and inverts on each later status read. Bits DATA_W-3..0 are 0.
- R7: After completion, a read returns array data: the true bits, no toggling.
- R8: The operation completes in the same number of cycles whether or not any read takes place.
- R9: suspend_i during an erase raises ready_o after SUSP_LAT cycles. The count stops while suspended. If the count expires during the latency, the erase completes instead.
- R10: While suspended, a read whose rd_sector_i differs from the captured erase sector returns array_data_i. A read of the erasing sector returns the status word and advances the toggle bit.
- R11: resume_i while suspended drops ready_o in the next cycle, and the erase finishes after its remaining count.
- R12: start_i is ignored while a program, an erase or a suspend is in place. suspend_i is ignored during a program. resume_i is ignored unless suspended.
- R13: Asserting rst_ni low in the middle of an operation raises ready_o at once, and later reads return array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; aborts any operation |
| start_i | input | 1 | One-cycle strobe from the command decoder launching an operation |
| op_erase_i | input | 1 | Operation type at start: 1 erase, 0 program |
| prog_data_i | input | DATA_W | Data being programmed, captured at start |
| erase_sector_i | input | SECT_W | Sector being erased, captured at start |
| suspend_i | input | 1 | Erase suspend request |
| resume_i | input | 1 | Erase resume request |
| rd_i | input | 1 | One-cycle read access strobe |
| rd_sector_i | input | SECT_W | Sector of the read address |
| array_data_i | input | DATA_W | Array contents at the read address |
| rd_data_o | output | DATA_W | Value returned to the host for the last read |
| ready_o | output | 1 | 1 ready, 0 busy |

## Verification
A wrong state or counter shows up first on ready_o, which exposes the state on every cycle. A count that is off by one moves the busy-to-ready edge by a cycle. A missed suspend or resume leaves ready_o at the wrong level within SUSP_LAT+1 cycles. A bad polling bit or toggle bit shows on the very next read, so the bench mixes dense and sparse reads. It also reads the erasing sector and other sectors while suspended, so that a wrong sector comparison surfaces as array data where status is expected, or the reverse.

// File: rtl/eo_pkg.sv
package eo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_ERASE = 3'd2,
    ST_SPEND = 3'd3,  // suspend requested, latency running
    ST_SUSP  = 3'd4
  } eo_state_e;
endpackage

// File: rtl/eo_timer.sv
module eo_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/eo_ctrl.sv
module eo_ctrl
  import eo_pkg::*;
#(
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 150,
  parameter int SUSP_LAT     = 4,
  parameter int CNT_W        = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             erase_i,
  input  logic             suspend_i,
  input  logic             resume_i,
  input  logic             done_i,
  output eo_state_e        state_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             run_o,
  output logic             ready_o
);
  localparam int LAT_W = (SUSP_LAT > 1) ? $clog2(SUSP_LAT) : 1;

  eo_state_e        st_q;
  logic [LAT_W-1:0] lat_q;

  assign state_o    = st_q;
  assign load_o     = (st_q == ST_IDLE) && start_i;
  assign load_val_o = erase_i ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1);
  assign run_o      = (st_q == ST_PROG) || (st_q == ST_ERASE) || (st_q == ST_SPEND);
  assign ready_o    = (st_q == ST_IDLE) || (st_q == ST_SUSP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      lat_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE:  if (start_i) st_q <= erase_i ? ST_ERASE : ST_PROG;
        ST_PROG:  if (done_i) st_q <= ST_IDLE;
        ST_ERASE: begin
          if (done_i) st_q <= ST_IDLE;
          else if (suspend_i) begin
            st_q  <= ST_SPEND;
            lat_q <= LAT_W'(SUSP_LAT - 1);
          end
        end
        ST_SPEND: begin
          // completion wins over a pending suspend
          if (done_i)             st_q  <= ST_IDLE;
          else if (lat_q == '0)   st_q  <= ST_SUSP;
          else                    lat_q <= lat_q - 1'b1;
        end
        ST_SUSP:  if (resume_i) st_q <= ST_ERASE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eo_status.sv
module eo_status
  import eo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SECT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  eo_state_e         state_i,
  input  logic [DATA_W-1:0] pdata_i,
  input  logic [SECT_W-1:0] sect_i,
  input  logic              rd_i,
  input  logic [SECT_W-1:0] rd_sector_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int POLL_B = DATA_W - 1;
  localparam int TOG_B  = DATA_W - 2;

  logic              tog_q;
  logic              busy_run;
  logic              stat_sel;
  logic [DATA_W-1:0] stat_w;
  logic [DATA_W-1:0] rd_q;

  assign busy_run = (state_i == ST_PROG) || (state_i == ST_ERASE) || (state_i == ST_SPEND);
  assign stat_sel = busy_run || ((state_i == ST_SUSP) && (rd_sector_i == sect_i));

  always_comb begin
    stat_w         = '0;
    stat_w[POLL_B] = (state_i == ST_PROG) ? ~pdata_i[POLL_B] : 1'b0;
    stat_w[TOG_B]  = tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      if (load_i)                tog_q <= 1'b0;
      else if (rd_i && stat_sel) tog_q <= ~tog_q;
      if (rd_i) rd_q <= stat_sel ? stat_w : array_data_i;
    end
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/eo_status_rpt.sv
module eo_status_rpt
  import eo_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SECT_W       = 4,
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 150,
  parameter int SUSP_LAT     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_erase_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic [SECT_W-1:0] erase_sector_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  input  logic              rd_i,
  input  logic [SECT_W-1:0] rd_sector_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              ready_o
);
  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  eo_state_e         state;
  logic              load;
  logic [CNT_W-1:0]  load_val;
  logic              run;
  logic              done;
  logic [DATA_W-1:0] pdata_q;
  logic [SECT_W-1:0] sect_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pdata_q <= '0;
      sect_q  <= '0;
    end else if (load) begin
      pdata_q <= prog_data_i;
      sect_q  <= erase_sector_i;
    end
  end

  eo_ctrl #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES),
    .SUSP_LAT    (SUSP_LAT),
    .CNT_W       (CNT_W)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .erase_i   (op_erase_i),
    .suspend_i (suspend_i),
    .resume_i  (resume_i),
    .done_i    (done),
    .state_o   (state),
    .load_o    (load),
    .load_val_o(load_val),
    .run_o     (run),
    .ready_o   (ready_o)
  );

  eo_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .run_i     (run),
    .done_o    (done)
  );

  eo_status #(.DATA_W(DATA_W), .SECT_W(SECT_W)) u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .state_i     (state),
    .pdata_i     (pdata_q),
    .sect_i      (sect_q),
    .rd_i        (rd_i),
    .rd_sector_i (rd_sector_i),
    .array_data_i(array_data_i),
    .rd_data_o   (rd_data_o)
  );
endmodule

// File: rtl/eo_status_rpt_chk.sv
module eo_status_rpt_chk
  import eo_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              suspend_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] array_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              ready_o,
  input eo_state_e         state,
  input logic [DATA_W-1:0] pdata_q
);
  // R3
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state == ST_IDLE) |=> !ready_o);
  // R2
  idle_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && state == ST_IDLE) |=> rd_data_o == $past(array_data_i));
  // R2
  read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_data_o));
  // R4
  prog_poll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && state == ST_PROG) |=> rd_data_o[DATA_W-1] != $past(pdata_q[DATA_W-1]));
  // R5
  erase_poll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (state == ST_ERASE || state == ST_SPEND)) |=> !rd_data_o[DATA_W-1]);
  // R9
  susp_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_SUSP |-> ready_o);
  // R12
  prog_nosusp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_PROG && suspend_i) |=> (state != ST_SPEND && state != ST_SUSP));
endmodule

bind eo_status_rpt eo_status_rpt_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .suspend_i   (suspend_i),
  .rd_i        (rd_i),
  .array_data_i(array_data_i),
  .rd_data_o   (rd_data_o),
  .ready_o     (ready_o),
  .state       (state),
  .pdata_q     (pdata_q)
);

// File: tb/eo_status_rpt_tb.sv
module eo_status_rpt_tb;
  localparam int CLK_PER = 10;
  localparam int DW = 8;
  localparam int SW = 4;
  localparam int PC = 16;
  localparam int EC = 150;
  localparam int SL = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0, op_erase = 1'b0, suspend = 1'b0, resume = 1'b0, rd = 1'b0;
  logic [DW-1:0] pdata = '0, arr = '0;
  logic [SW-1:0] esect = '0, rsect = '0;
  logic [DW-1:0] rd_data;
  logic ready;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;

  // behavioural model: 0 idle,1 prog,2 erase,3 suspend pending,4 suspended
  int m_st = 0, m_rem = 0, m_lat = 0;
  logic [DW-1:0] m_data = '0, m_out = '0;
  logic [SW-1:0] m_sect = '0;
  bit m_tog = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  eo_status_rpt #(.DATA_W(DW), .SECT_W(SW), .PROG_CYCLES(PC),
                  .ERASE_CYCLES(EC), .SUSP_LAT(SL)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .op_erase_i(op_erase),
    .prog_data_i(pdata), .erase_sector_i(esect), .suspend_i(suspend),
    .resume_i(resume), .rd_i(rd), .rd_sector_i(rsect), .array_data_i(arr),
    .rd_data_o(rd_data), .ready_o(ready));

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 100000", cyc);
      finish_run();
    end
  end

  task automatic model_step();
    bit done, stat;
    done = (m_st >= 1 && m_st <= 3) && (m_rem == 0);
    if (rd) begin
      stat = (m_st >= 1 && m_st <= 3) || (m_st == 4 && rsect == m_sect);
      if (stat) begin
        m_out = '0;
        m_out[DW-1] = (m_st == 1) ? ~m_data[DW-1] : 1'b0;
        m_out[DW-2] = m_tog;
        m_tog = ~m_tog;
      end else m_out = arr;
    end
    case (m_st)
      0: if (start) begin
        m_st = op_erase ? 2 : 1;
        m_rem = (op_erase ? EC : PC) - 1;
        m_data = pdata; m_sect = esect; m_tog = 1'b0;
      end
      1: if (done) m_st = 0; else m_rem--;
      2: if (done) m_st = 0;
         else begin
           m_rem--;
           if (suspend) begin m_st = 3; m_lat = SL - 1; end
         end
      3: if (done) m_st = 0;
         else begin
           m_rem--;
           if (m_lat == 0) m_st = 4; else m_lat--;
         end
      4: if (resume) m_st = 2;
      default: m_st = 0;
    endcase
  endtask

  task automatic compare(input string tag);
    bit exp_rdy;
    exp_rdy = (m_st == 0 || m_st == 4);
    vectors++;
    if (ready !== exp_rdy || rd_data !== m_out) begin
      fails++;
      $display("FAIL %s: actual ready=%0b data=%02h expected ready=%0b data=%02h",
               tag, ready, rd_data, exp_rdy, m_out);
    end
  endtask

  // apply the inputs currently set, advance one clock, compare, clear strobes
  task automatic tick(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    start = 0; suspend = 0; resume = 0; rd = 0;
  endtask

  task automatic do_read(input logic [SW-1:0] s, input logic [DW-1:0] a, input string tag);
    rd = 1; rsect = s; arr = a;
    tick(tag);
  endtask

  task automatic launch(input bit er, input logic [DW-1:0] d, input logic [SW-1:0] s, input string tag);
    start = 1; op_erase = er; pdata = d; esect = s;
    tick(tag);
  endtask

  task automatic idle_until_ready(input string tag);
    for (int i = 0; i < EC + 10 && !ready; i++) tick(tag);
  endtask

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    vectors++;
    if (ready !== 1'b1 || rd_data !== '0) begin
      fails++;
      $display("FAIL R1: actual ready=%0b data=%02h expected ready=1 data=00", ready, rd_data);
    end
    rst_ni = 1;
    tick("R1");

    // R2: idle pass-through, several patterns, hold without read
    do_read(4'h1, 8'hA5, "R2");
    do_read(4'h7, 8'h5A, "R2");
    arr = 8'hFF; tick("R2");
    do_read(4'h2, 8'h00, "R2");

    // R3 R4 R6 R7: program with bit7 set, read every other cycle
    launch(1'b0, 8'h80, 4'h0, "R3");
    for (int i = 0; i < PC + 2; i++) begin
      if (i % 2 == 0) do_read(4'h0, 8'h80, "R4"); else tick("R6");
    end
    do_read(4'h0, 8'h80, "R7");
    do_read(4'h0, 8'h80, "R7");

    // R4 R6 R12: program with bit7 clear, dense reads, stray start/suspend/resume
    launch(1'b0, 8'h3C, 4'h0, "R3");
    do_read(4'h0, 8'h3C, "R6");
    start = 1; op_erase = 1; pdata = 8'hFF; tick("R12");
    suspend = 1; tick("R12");
    resume = 1; tick("R12");
    for (int i = 0; i < PC; i++) do_read(4'h3, 8'h3C, "R4");
    do_read(4'h3, 8'h3C, "R7");

    // R8: program with no reads completes on time
    launch(1'b0, 8'h11, 4'h0, "R8");
    for (int i = 0; i < PC + 1; i++) tick("R8");
    do_read(4'h0, 8'h11, "R8");

    // R5 R9 R10 R11 R12: erase sector 5, suspend, mixed sector reads, resume
    launch(1'b1, 8'h00, 4'h5, "R3");
    for (int i = 0; i < 20; i++) begin
      if (i % 3 == 0) do_read(4'h2, 8'h77, "R5"); else tick("R3");
    end
    suspend = 1; tick("R9");
    for (int i = 0; i < SL; i++) do_read(4'h2, 8'h66, "R9");
    tick("R9");
    do_read(4'h2, 8'hC3, "R10");
    do_read(4'h5, 8'hC3, "R10");
    do_read(4'h5, 8'hC3, "R10");
    do_read(4'h9, 8'h42, "R10");
    start = 1; op_erase = 0; pdata = 8'h01; tick("R12");
    suspend = 1; tick("R12");
    repeat (30) tick("R9");
    resume = 1; tick("R11");
    do_read(4'h5, 8'hEE, "R11");
    idle_until_ready("R11");
    repeat (2) tick("R11");
    do_read(4'h5, 8'hFF, "R7");

    // R9: suspend requested just before the count expires, completion wins
    launch(1'b1, 8'h00, 4'h1, "R3");
    for (int i = 0; i < EC - 3; i++) tick("R3");
    suspend = 1; tick("R9");
    repeat (SL + 3) tick("R9");
    do_read(4'h1, 8'h5F, "R9");

    // R13: reset mid-erase
    launch(1'b1, 8'h00, 4'h3, "R3");
    repeat (10) do_read(4'h3, 8'h12, "R13");
    rst_ni = 0;
    m_st = 0; m_rem = 0; m_lat = 0; m_out = '0; m_tog = 1'b0; m_data = '0; m_sect = '0;
    #1;
    compare("R13");
    @(negedge clk);
    rst_ni = 1;
    tick("R13");
    do_read(4'h3, 8'h9C, "R13");

    finish_run();
  end
endmodule